// File: doc/BRIEF.md
# Muxed Programmable Frequency Generator Bank

The block holds six programmable frequency generators that all run on a single fast system clock. Each generator selects one of three source-rate strobes. These strobes are single-cycle clock enables that stand in for three phase-locked-loop outputs: the core PLL, the auxiliary PLL and a second auxiliary PLL. The generator counts the strobes of its chosen source and divides them by a programmable ratio. For each generator it drives two outputs: a one-cycle divided strobe at every terminal count, and a square-wave level.

Software controls the bank through two 32-bit control words on a simple write/read port. Each word carries three 10-bit generator fields. A build parameter picks one of two field formats. The legacy format has a source bit, an enable bit and an even-only divisor. The extended format has a two-bit source code where code 0 switches the generator off. It also has one scale bit per word, and that bit lets the three generators in the word divide by any integer. A new source or divisor takes effect only at a terminal count, so no period is ever cut short.

Top module: `fgen_bank`

## Requirements
- R1: After reset both control words read as zero and every `gen_stb` and `gen_clk` output is low.
- R2: A read returns the last value written to that word with the reserved bits forced to zero. Bit 31 is reserved in both formats, and bit 30 is also reserved in the legacy format.
- R3: Generator k uses control word k/3, with its 10-bit field starting at bit 10*(k mod 3). Inside a field, bits 9:2 hold the divisor code N.
- R4: Legacy format: field bit 0 picks the source (0 core PLL, 1 auxiliary PLL) and field bit 1 enables the generator. The divide ratio is 2*(N+1).
- R5: Extended format: field bits 1:0 form the source code. Code 0 turns the generator off, 1 selects the second auxiliary PLL, 2 the core PLL and 3 the auxiliary PLL.
- R6: Extended format: bit 30 of a word is a scale bit for the three generators of that word only. When it is set the ratio is N+1, and when it is clear the ratio is 2*(N+1).
- R7: A generator counts only strobes of its selected source. Its `gen_stb` is high for one cycle once every ratio strobes, so consecutive pulses are ratio times the source strobe spacing apart.
- R8: Within each period `gen_clk` is high for floor(ratio/2) strobes, starting at the terminal count, and low for the rest. With a ratio of 1 it stays low.
- R9: A disabled generator keeps `gen_stb` and `gen_clk` low from the next cycle on and holds its count at zero. When it is enabled again, the first pulse comes a full ratio of strobes after the enabling write.
- R10: A divisor written while a generator runs leaves the current period at its old length. The new ratio applies from the next terminal count onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for every register in the bank |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the addressed control word |
| cfg_addr | input | 1 | Control word select (0 holds generators 0-2, 1 holds 3-5) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed control word, combinational |
| cpu_pll_stb | input | 1 | Core PLL rate strobe |
| aux_pll_stb | input | 1 | Auxiliary PLL rate strobe |
| aux2_pll_stb | input | 1 | Second auxiliary PLL rate strobe |
| gen_stb | output | 6 | Divided strobe per generator, one cycle at each terminal count |
| gen_clk | output | 6 | Square-wave output per generator |

## Verification
The bench aims at the places where the ratio arithmetic is easy to get wrong: the odd ratio of 5, where the high phase must be two strobes and not three; a ratio of 1, where the square wave must stay low; and a ratio of 512, where a one-bit-short counter would wrap at 256. It runs the three sources at different strobe spacings, so a swapped select code shows up as a wrong period, and it runs two words with different scale settings, so a scale bit that leaked into the other word would halve or double a period. A divisor rewrite in mid-period catches a design that reloads at once and produces a short pulse. Re-enabling after a disable catches a counter that was not cleared, because the first pulse would then arrive early.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

  localparam int REG_W       = 32;
  localparam int FIELD_W     = 10;
  localparam int DIV_W       = 8;
  localparam int RATIO_W     = DIV_W + 2;
  localparam int GEN_PER_REG = 3;
  localparam int NUM_REGS    = 2;
  localparam int NUM_GEN     = NUM_REGS * GEN_PER_REG;
  localparam int FIELDS_W    = FIELD_W * GEN_PER_REG;
  localparam int SCALE_POS   = FIELDS_W;
  localparam int NUM_SRC     = 3;
  localparam int ADDR_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  typedef enum logic [1:0] {
    SRC_CPU  = 2'd0,
    SRC_AUX  = 2'd1,
    SRC_AUX2 = 2'd2
  } src_e;

  typedef struct packed {
    logic               en;
    src_e               src;
    logic [RATIO_W-1:0] ratio;
  } gen_cfg_t;

endpackage

// File: rtl/fgen_rst_sync.sv
module fgen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fgen_regs.sv
module fgen_regs
  import fgen_pkg::*;
#(
  parameter bit EXT_FMT = 1'b1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [REG_W-1:0]                   wdata,
  output logic [REG_W-1:0]                   rdata,
  output logic [NUM_REGS-1:0][FIELDS_W-1:0]  fld,
  output logic [NUM_REGS-1:0]                scale
);

  logic [NUM_REGS-1:0][FIELDS_W-1:0] fld_q, fld_d;
  logic [NUM_REGS-1:0]               scale_q;
  logic [NUM_REGS-1:0]               wr_hit;
  logic                              unused_wtop;

  assign unused_wtop = wdata[REG_W-1];

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      wr_hit[r] = we && (addr == ADDR_W'(r));
      fld_d[r]  = wdata[FIELDS_W-1:0];
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          fld_q[r] <= '0;
      else if (wr_hit[r])  fld_q[r] <= fld_d[r];
    end

    if (EXT_FMT) begin : g_scale
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          scale_q[r] <= 1'b0;
        else if (wr_hit[r])  scale_q[r] <= wdata[SCALE_POS];
      end
    end else begin : g_noscale
      logic unused_scale_bit;
      assign unused_scale_bit = wdata[SCALE_POS];
      assign scale_q[r] = 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (addr == ADDR_W'(r))
        rdata = {{(REG_W-FIELDS_W-1){1'b0}}, scale_q[r], fld_q[r]};
    end
  end

  assign fld   = fld_q;
  assign scale = scale_q;

endmodule

// File: rtl/fgen_field_dec.sv
module fgen_field_dec
  import fgen_pkg::*;
#(
  parameter bit EXT_FMT = 1'b1
) (
  input  logic [FIELD_W-1:0] fld,
  input  logic               scale,
  output gen_cfg_t           cfg
);

  logic [RATIO_W-1:0] n_plus1;

  assign n_plus1 = RATIO_W'(fld[FIELD_W-1:2]) + RATIO_W'(1);

  if (EXT_FMT) begin : g_ext
    always_comb begin
      cfg.en = (fld[1:0] != 2'b00);
      unique case (fld[1:0])
        2'd1:    cfg.src = SRC_AUX2;
        2'd2:    cfg.src = SRC_CPU;
        2'd3:    cfg.src = SRC_AUX;
        default: cfg.src = SRC_CPU;
      endcase
      cfg.ratio = scale ? n_plus1 : (n_plus1 << 1);
    end
  end else begin : g_leg
    logic unused_leg_scale;
    assign unused_leg_scale = scale;
    always_comb begin
      cfg.en    = fld[1];
      cfg.src   = fld[0] ? SRC_AUX : SRC_CPU;
      cfg.ratio = n_plus1 << 1;
    end
  end

endmodule

// File: rtl/fgen_div.sv
module fgen_div
  import fgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  gen_cfg_t           req_cfg,
  input  logic [NUM_SRC-1:0] src_stb,
  output logic               gen_stb,
  output logic               gen_clk
);

  gen_cfg_t           act_q, act_d, eff;
  logic [RATIO_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic               stb_q, stb_d, sq_q, sq_d;
  logic               hit, term;

  always_comb begin
    eff = act_q.en ? act_q : req_cfg;
    unique case (eff.src)
      SRC_CPU:  hit = src_stb[0];
      SRC_AUX:  hit = src_stb[1];
      SRC_AUX2: hit = src_stb[2];
      default:  hit = 1'b0;
    endcase
  end

  assign cnt_inc = cnt_q + RATIO_W'(1);
  assign term    = (cnt_q == (eff.ratio - RATIO_W'(1)));

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    stb_d = 1'b0;
    sq_d  = sq_q;
    if (!req_cfg.en) begin
      cnt_d = '0;
      act_d = req_cfg;
      sq_d  = 1'b0;
    end else begin
      if (!act_q.en) act_d = req_cfg;
      if (hit) begin
        if (term) begin
          cnt_d = '0;
          act_d = req_cfg;
          stb_d = 1'b1;
          sq_d  = ((req_cfg.ratio >> 1) != '0);
        end else begin
          cnt_d = cnt_inc;
          sq_d  = (cnt_inc < (eff.ratio >> 1));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
      stb_q <= 1'b0;
      sq_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      stb_q <= stb_d;
      sq_q  <= sq_d;
    end
  end

  assign gen_stb = stb_q;
  assign gen_clk = sq_q;

endmodule

// File: rtl/fgen_bank.sv
module fgen_bank
  import fgen_pkg::*;
#(
  parameter bit EXT_FMT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  input  logic                cpu_pll_stb,
  input  logic                aux_pll_stb,
  input  logic                aux2_pll_stb,
  output logic [NUM_GEN-1:0]  gen_stb,
  output logic [NUM_GEN-1:0]  gen_clk
);

  logic                              rst_sync_n;
  logic [NUM_REGS-1:0][FIELDS_W-1:0] fld;
  logic [NUM_REGS-1:0]               scale;
  logic [NUM_SRC-1:0]                src_vec;
  logic [NUM_GEN-1:0]                gen_en;
  logic                              fmt_ext;
  gen_cfg_t                          cfg [NUM_GEN];

  assign src_vec = {aux2_pll_stb, aux_pll_stb, cpu_pll_stb};
  assign fmt_ext = EXT_FMT;

  fgen_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fgen_regs #(.EXT_FMT(EXT_FMT)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .fld   (fld),
    .scale (scale)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam int WORD = g / GEN_PER_REG;
    localparam int OFF  = (g % GEN_PER_REG) * FIELD_W;

    fgen_field_dec #(.EXT_FMT(EXT_FMT)) u_dec (
      .fld   (fld[WORD][OFF +: FIELD_W]),
      .scale (scale[WORD]),
      .cfg   (cfg[g])
    );

    assign gen_en[g] = cfg[g].en;

    fgen_div u_div (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .req_cfg (cfg[g]),
      .src_stb (src_vec),
      .gen_stb (gen_stb[g]),
      .gen_clk (gen_clk[g])
    );
  end

endmodule

// File: rtl/fgen_bank_chk.sv
module fgen_bank_chk
  import fgen_pkg::*;
(
  input logic               clk,
  input logic               rst_sync_n,
  input logic               fmt_ext,
  input logic               cfg_we,
  input logic [ADDR_W-1:0]  cfg_addr,
  input logic [REG_W-1:0]   cfg_wdata,
  input logic [REG_W-1:0]   cfg_rdata,
  input logic [NUM_SRC-1:0] src_vec,
  input logic [NUM_GEN-1:0] gen_en,
  input logic [NUM_GEN-1:0] gen_stb,
  input logic [NUM_GEN-1:0] gen_clk
);

  logic [REG_W-1:0] keep_mask;
  assign keep_mask = fmt_ext ? 32'h7FFF_FFFF : 32'h3FFF_FFFF;

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_rdata & ~keep_mask) == '0);

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(cfg_we) && cfg_addr == $past(cfg_addr))
      |-> cfg_rdata == ($past(cfg_wdata) & keep_mask));

  for (genvar i = 0; i < NUM_GEN; i++) begin : g_gen_chk
    // R9
    quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !gen_en[i] |=> (!gen_stb[i] && !gen_clk[i]));

    // R7
    stb_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      gen_stb[i] |-> $past(|src_vec));

    // R7
    stb_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      gen_stb[i] |-> $past(gen_en[i]));
  end

endmodule

bind fgen_bank fgen_bank_chk u_fgen_bank_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .fmt_ext    (fmt_ext),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .src_vec    (src_vec),
  .gen_en     (gen_en),
  .gen_stb    (gen_stb),
  .gen_clk    (gen_clk)
);

// File: tb/fgen_bank_bench.sv
`timescale 1ns/1ps
module fgen_bank_bench;

  logic        clk;
  logic        rst_n;
  logic        we_ext, we_leg;
  logic        addr;
  logic [31:0] wdata;
  logic [31:0] rd_ext, rd_leg;
  logic        run;
  logic        cpu_s, aux_s, aux2_s;
  logic [5:0]  stb_ext, clk_ext, stb_leg, clk_leg;

  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  int   ph     = 0;
  int   last_wr = 0;
  bit   use_leg = 0;

  fgen_bank #(.EXT_FMT(1'b1)) u_fgen_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_ext), .cfg_addr(addr),
    .cfg_wdata(wdata), .cfg_rdata(rd_ext),
    .cpu_pll_stb(cpu_s), .aux_pll_stb(aux_s), .aux2_pll_stb(aux2_s),
    .gen_stb(stb_ext), .gen_clk(clk_ext));

  fgen_bank #(.EXT_FMT(1'b0)) u_fgen_bank_leg (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_leg), .cfg_addr(addr),
    .cfg_wdata(wdata), .cfg_rdata(rd_leg),
    .cpu_pll_stb(cpu_s), .aux_pll_stb(aux_s), .aux2_pll_stb(aux2_s),
    .gen_stb(stb_leg), .gen_clk(clk_leg));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) ph <= ph + 1;

  // core strobe every cycle, auxiliary every 2nd, second auxiliary every 3rd
  assign cpu_s  = run;
  assign aux_s  = run && (ph % 2 == 0);
  assign aux2_s = run && (ph % 3 == 0);

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit get_stb(input int g);
    return use_leg ? stb_leg[g] : stb_ext[g];
  endfunction

  function automatic bit get_clk(input int g);
    return use_leg ? clk_leg[g] : clk_ext[g];
  endfunction

  task automatic wr(input bit leg, input bit a, input logic [31:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    if (leg) we_leg = 1'b1; else we_ext = 1'b1;
    last_wr = cyc;
    @(negedge clk);
    we_leg = 1'b0;
    we_ext = 1'b0;
  endtask

  task automatic rd(input bit leg, input bit a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = leg ? rd_leg : rd_ext;
  endtask

  // waits for the next pulse of generator g; returns the cycle it was seen in
  task automatic wait_pulse(input int g, output int at, output bit ok);
    ok = 1'b0;
    at = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (get_stb(g)) begin
        ok = 1'b1;
        at = cyc;
        break;
      end
    end
  endtask

  // skips one pulse, then measures one full period and its high time
  task automatic measure(input int g, output int per, output int hi);
    int  at;
    bit  ok;
    per = 0;
    hi  = 0;
    wait_pulse(g, at, ok);
    if (ok) wait_pulse(g, at, ok);
    if (!ok) return;
    do begin
      hi  += int'(get_clk(g));
      per++;
      @(negedge clk);
    end while (!get_stb(g) && per < 4000);
  endtask

  task automatic expect_period(input string req, input int g, input int exp_per, input int exp_hi);
    int per, hi;
    measure(g, per, hi);
    chk(req, $sformatf("gen%0d period", g), per, exp_per);
    chk(req, $sformatf("gen%0d high time", g), hi, exp_hi);
  endtask

  task automatic expect_quiet(input string req, input int g);
    int bad = 0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (get_stb(g) || get_clk(g)) bad++;
    end
    chk(req, $sformatf("gen%0d active cycles while off", g), bad, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 0, d); chk("R1", "ext word0 after reset", d, 0);
    rd(0, 1, d); chk("R1", "ext word1 after reset", d, 0);
    rd(1, 0, d); chk("R1", "legacy word0 after reset", d, 0);
    chk("R1", "outputs after reset", {stb_ext, clk_ext, stb_leg, clk_leg}, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(0, 0, 32'hFFFF_FFFF); rd(0, 0, d);
    chk("R2", "ext readback bit31 reserved", d, 32'h7FFF_FFFF);
    wr(1, 1, 32'hFFFF_FFFF); rd(1, 1, d);
    chk("R2", "legacy readback bits31:30 reserved", d, 32'h3FFF_FFFF);
    wr(0, 1, 32'h1234_5678); rd(0, 1, d);
    chk("R2", "ext readback pattern", d, 32'h1234_5678);
    wr(0, 0, 0); wr(0, 1, 0); wr(1, 1, 0);
  endtask

  task automatic t_ext_basic();
    use_leg = 0;
    // gen0: code 2 (core), N=3, scale clear -> ratio 8
    wr(0, 0, 32'd14);
    expect_period("R5_R6", 0, 8, 4);
  endtask

  task automatic t_ext_scale();
    use_leg = 0;
    // word0 scale set: gen1 code2 N=4 -> ratio 5; gen2 code3 N=0 -> ratio 1
    wr(0, 0, (32'd1 << 30) | (32'd18 << 10) | (32'd3 << 20));
    // word1 scale clear: gen4 code3 N=0 -> ratio 2; gen5 code1 N=1 -> ratio 4
    wr(0, 1, (32'd3 << 10) | (32'd5 << 20));
    expect_period("R6", 1, 5, 2);
    expect_period("R8", 2, 2, 0);
    expect_period("R3", 4, 4, 2);
    expect_period("R7", 5, 12, 6);
    expect_quiet("R5", 0);
  endtask

  task automatic t_ext_disable();
    int  at;
    bit  ok;
    use_leg = 0;
    wr(0, 0, 32'd14);
    wait_pulse(0, at, ok);
    wr(0, 0, 32'd0);
    expect_quiet("R9", 0);
    wr(0, 0, 32'd14);
    wait_pulse(0, at, ok);
    chk("R9", "first pulse after re-enable (cycles)", ok ? at - last_wr : -1, 9);
  endtask

  task automatic t_ext_reload();
    int  t0, t1, t2;
    bit  ok;
    use_leg = 0;
    wr(0, 0, 32'd14);
    wait_pulse(0, t0, ok);
    wait_pulse(0, t0, ok);
    wr(0, 0, 32'd2);            // code 2, N=0 -> ratio 2
    wait_pulse(0, t1, ok);
    wait_pulse(0, t2, ok);
    chk("R10", "period in which divisor changed", t1 - t0, 8);
    chk("R10", "period after reload", t2 - t1, 2);
  endtask

  task automatic t_legacy();
    use_leg = 1;
    // gen0: core, enabled, N=255 -> ratio 512; gen1: disabled, N=5; gen2: aux, enabled, N=1 -> ratio 4
    wr(1, 0, 32'h3FE | (32'd20 << 10) | (32'd7 << 20));
    expect_period("R4", 2, 8, 4);
    expect_period("R4", 0, 512, 256);
    expect_quiet("R4", 1);
    use_leg = 0;
  endtask

  initial begin
    rst_n  = 1'b0;
    run    = 1'b0;
    we_ext = 1'b0;
    we_leg = 1'b0;
    addr   = 1'b0;
    wdata  = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    run = 1'b1;
    t_readback();
    t_ext_basic();
    t_ext_scale();
    t_ext_disable();
    t_ext_reload();
    t_legacy();
    summary();
    $finish;
  end

endmodule